// File: doc/BRIEF.md
# Relocating Bounds Guard for Processor Addresses

This block sits between a processor and its memory path. It takes one logical address per cycle and decides, in a single registered stage, whether that access may go on. For a user-mode access the logical address is first compared with a size value, the limit. An address strictly below the limit is legal. It is then moved into physical space by adding a relocation value, the base, and forwarded with a strobe one cycle later. An address at or above the limit is not forwarded. The block raises a one-cycle trap instead and registers the offending logical address with it.

Supervisor-mode accesses skip both the limit check and the addition. They come out unchanged, zero-extended to the physical width. The base and limit are loaded through a small write port. A write is accepted only in a cycle with no request, and it governs every request from the next cycle on.

Top module: `reloc_guard`

## Requirements
- R1: After reset, out_valid, trap, out_addr and trap_addr are all 0, and both base and limit are 0, so the first user-mode access traps.
- R2: A user-mode request (req_user=1) whose logical address is strictly below the limit produces out_valid=1 one cycle later, with out_addr equal to the logical address plus the base, taken modulo 2^PW.
- R3: A user-mode request whose address is equal to or above the limit produces trap=1 for one cycle, one cycle later. In that cycle out_valid=0 and trap_addr holds the logical address.
- R4: A supervisor-mode request (req_user=0) is always forwarded one cycle later, whatever the limit. out_addr is then the logical address zero-extended, with no base added.
- R5: A cycle with req_valid=0 gives out_valid=0 and trap=0 one cycle later. out_addr is 0 whenever out_valid is 0, and trap_addr is 0 whenever trap is 0.
- R6: With cfg_we=1 and req_valid=0, cfg_data is loaded into the base when cfg_sel=0 and into the limit when cfg_sel=1. A request presented in the very next cycle already uses the new value.
- R7: A configuration write presented in the same cycle as req_valid=1 is ignored, and the base and limit keep their values.
- R8: out_valid and trap are never 1 in the same cycle.
- R9: With limit 151 and base 2000, logical addresses 0 to 150 map to 2000 to 2150 and address 151 traps. With base 4000, address 150 maps to 4150.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | AW | Logical address of the request |
| req_user | input | 1 | 1 = user mode (checked, relocated), 0 = supervisor |
| cfg_we | input | 1 | Write strobe for base or limit |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_data | input | PW | Value to load |
| out_valid | output | 1 | Forwarded request strobe |
| out_addr | output | PW | Physical address of the forwarded request |
| trap | output | 1 | One-cycle violation pulse |
| trap_addr | output | AW | Logical address that caused the trap |

## Verification
The bench builds the block with AW=12 and PW=16. A 16-bit limit can then take the value 4096, which lies above every 12-bit logical address. This makes both extremes reachable: limit 0, where every user access traps, and limit 4096, where none does. The physical width also leaves room to drive a base near 2^16, so the modulo wrap of the addition is exercised alongside the worked example around 2000 and 4000.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [PW-1:0] cfg_data,
  input  logic          busy,
  output logic [PW-1:0] base_q,
  output logic [PW-1:0] limit_q
);
  import reloc_pkg::*;

  logic wr_accept;
  logic wr_base;
  logic wr_limit;

  assign wr_accept = cfg_we && !busy;
  assign wr_base   = wr_accept && (cfg_sel == SEL_BASE);
  assign wr_limit  = wr_accept && (cfg_sel == SEL_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      if (wr_base)  base_q  <= cfg_data;
      if (wr_limit) limit_q <= cfg_data;
    end
  end

  // R7: writes overlapping a request leave both registers alone
  assert_hold_in_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> ($stable(base_q) && $stable(limit_q)));

  // R6: an accepted write lands in the selected register only
  assert_base_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |=> (base_q == $past(cfg_data)) && $stable(limit_q));
  assert_limit_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_limit |=> (limit_q == $past(cfg_data)) && $stable(base_q));
endmodule

// File: rtl/reloc_check.sv
module reloc_check #(
  parameter int AW = 12,
  parameter int PW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          user,
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] limit,
  output logic          pass,
  output logic          fault,
  output logic [PW-1:0] phys
);
  localparam int EXT = PW - AW;

  function automatic logic [PW-1:0] widen(input logic [AW-1:0] a);
    return {{EXT{1'b0}}, a};
  endfunction

  function automatic logic below_limit(input logic [AW-1:0] a, input logic [PW-1:0] lim);
    return widen(a) < lim;
  endfunction

  function automatic logic [PW-1:0] add_base(input logic [AW-1:0] a, input logic [PW-1:0] b);
    return widen(a) + b;
  endfunction

  logic in_bounds;

  assign in_bounds = below_limit(addr, limit);
  assign pass      = !user || in_bounds;
  assign fault     = user && !in_bounds;
  assign phys      = user ? add_base(addr, base) : widen(addr);

  // R8: a request is either forwarded or faulted, never both
  always_comb begin
    assert_one_outcome_R8: assert (!(pass && fault));
  end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard #(
  parameter int AW = 12,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_user,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [PW-1:0] cfg_data,
  output logic          out_valid,
  output logic [PW-1:0] out_addr,
  output logic          trap,
  output logic [AW-1:0] trap_addr
);
  localparam int EXT = PW - AW;

  if (PW <= AW) begin : g_bad_width
    initial $error("reloc_guard needs PW > AW so the limit can cover all addresses");
  end

  logic [PW-1:0] base_q;
  logic [PW-1:0] limit_q;
  logic          chk_pass;
  logic          chk_fault;
  logic [PW-1:0] chk_phys;
  logic          fwd_evt;
  logic          trap_evt;

  reloc_regs #(.PW(PW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .busy     (req_valid),
    .base_q   (base_q),
    .limit_q  (limit_q)
  );

  reloc_check #(.AW(AW), .PW(PW)) u_check (
    .addr  (req_addr),
    .user  (req_user),
    .base  (base_q),
    .limit (limit_q),
    .pass  (chk_pass),
    .fault (chk_fault),
    .phys  (chk_phys)
  );

  assign fwd_evt  = req_valid && chk_pass;
  assign trap_evt = req_valid && chk_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      trap      <= 1'b0;
      trap_addr <= '0;
    end else begin
      out_valid <= fwd_evt;
      out_addr  <= fwd_evt ? chk_phys : '0;
      trap      <= trap_evt;
      trap_addr <= trap_evt ? req_addr : '0;
    end
  end

  // R3: a trap only follows a user-mode request at or past the limit
  assert_trap_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(req_valid && req_user && ({{EXT{1'b0}}, req_addr} >= limit_q)));

  // R2: user forward carries the relocated address
  assert_user_reloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(req_user)) |-> out_addr == $past(base_q + {{EXT{1'b0}}, req_addr}));

  // R4: supervisor forward is untouched
  assert_super_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_user) |=> out_valid && out_addr == {{EXT{1'b0}}, $past(req_addr)});

  // R5: an empty cycle yields no output activity
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !trap && out_addr == '0 && trap_addr == '0));

  // R8: the two output strobes exclude each other
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && trap));
endmodule

// File: tb/reloc_guard_tb_top.sv
module reloc_guard_tb_top;
  localparam int AW = 12;
  localparam int PW = 16;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_user = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [PW-1:0] cfg_data = '0;
  logic          out_valid;
  logic [PW-1:0] out_addr;
  logic          trap;
  logic [AW-1:0] trap_addr;

  int total = 0;
  int bad = 0;
  int m_base = 0;
  int m_limit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reloc_guard #(.AW(AW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_user(req_user), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_addr(out_addr), .trap(trap), .trap_addr(trap_addr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit legal(input int a, input int lim);
    return a < lim;
  endfunction

  function automatic int moved(input int a, input int b);
    return (a + b) % (1 << PW);
  endfunction

  // drive one cycle of inputs, then check the registered result
  task automatic step(input bit v, input int a, input bit u, input bit we,
                      input bit sel, input int d, input string tag);
    bit ev, et;
    int ea, eta;
    req_valid = v; req_addr = a[AW-1:0]; req_user = u;
    cfg_we = we; cfg_sel = sel; cfg_data = d[PW-1:0];
    ev  = v && (!u || legal(a, m_limit));
    et  = v && u && !legal(a, m_limit);
    ea  = ev ? (u ? moved(a, m_base) : a) : 0;
    eta = et ? a : 0;
    if (we && !v) begin
      if (sel) m_limit = d; else m_base = d;
    end
    @(negedge clk);
    chk(tag, "out_valid", int'(out_valid), int'(ev));
    chk(tag, "trap", int'(trap), int'(et));
    chk(tag, "out_addr", int'(out_addr), ea);
    chk(tag, "trap_addr", int'(trap_addr), eta);
    chk("R8", "both strobes", int'(out_valid && trap), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1", "out_valid at reset", int'(out_valid), 0);
    chk("R1", "trap at reset", int'(trap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_addr after reset", int'(out_addr), 0);
    chk("R1", "trap_addr after reset", int'(trap_addr), 0);
    step(1, 0, 1, 0, 0, 0, "R1");          // limit 0 -> trap
    step(1, 12'h123, 0, 0, 0, 0, "R4");    // supervisor ignores limit 0
    step(0, 0, 0, 1, 0, 2000, "R6");       // base
    step(0, 0, 0, 1, 1, 151, "R6");        // limit
    step(1, 0, 1, 0, 0, 0, "R9");
    step(1, 150, 1, 0, 0, 0, "R9");
    step(1, 151, 1, 0, 0, 0, "R9");
    step(1, 4095, 1, 0, 0, 0, "R3");
    step(1, 7, 0, 0, 0, 0, "R4");
    step(1, 10, 1, 1, 0, 4000, "R7");      // write during request ignored
    step(1, 10, 1, 0, 0, 0, "R7");         // still base 2000 -> 2010
    step(0, 0, 0, 1, 0, 4000, "R6");
    step(1, 150, 1, 0, 0, 0, "R9");        // next cycle already 4150
    step(0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 1, 4096, "R6");
    step(1, 4095, 1, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 16'hFF00, "R6");
    step(1, 12'h200, 1, 0, 0, 0, "R2");    // wraps to 0x0100
    step(0, 0, 0, 1, 1, 5, "R6");
    step(1, 4, 1, 0, 0, 0, "R2");
    step(1, 5, 1, 0, 0, 0, "R3");          // equal to limit traps
    for (int i = 0; i < 3000; i++) begin
      bit v, u, we, sel;
      int a, d;
      string tag;
      v   = ($urandom % 4) != 0;
      u   = ($urandom % 4) != 0;
      we  = ($urandom % 6) == 0;
      sel = $urandom % 2;
      a   = $urandom % (1 << AW);
      d   = sel ? (($urandom % 3 == 0) ? 4096 : $urandom % 4200) : $urandom % (1 << PW);
      if (!v) tag = we ? "R6" : "R5";
      else if (we) tag = "R7";
      else if (!u) tag = "R4";
      else if (legal(a, m_limit)) tag = "R2";
      else tag = "R3";
      step(v, a, u, we, sel, d, tag);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule